// File: doc/BRIEF.md
# Dual-Mode Serial Pad Controller

This block sits between two shared serial pins (a clock pin and a data pin) and two protocol engines, one SPI and one I2C. A mode input chooses which engine owns the pins. The block turns the owning engine's output intent into four drive-enable controls per pin: a strong pull-up, a weak pull-up and two pull-down legs. It also conditions the pin levels that come back in, with a separate path for each engine.

In SPI mode the pin is push/pull. The SPI engine's output level drives the strong pull-up or the first pull-down leg while its output enable is high. The second leg stays off. In I2C mode the pin is open-drain. A 0 from the I2C engine turns on both pull-down legs together, and a 1 releases them. Only the weak pull-up then holds the line high. Every incoming level first passes through a two-flop synchronizer. The I2C copies of clock and data then pass through a glitch rejector of `GLITCH_CYCLES` clocks, which must last longer than 50 ns. The SPI clock passes through a shorter hold filter of `SPI_HOLD` clocks, so that a slow, noisy edge cannot produce two transitions.

All engine-facing pins are plain level signals. No data is buffered, so there is no valid/ready handshake and no back-pressure.

Top module: `serial_pad_ctrl`

## Requirements
- R1: While `spi_mode` is 0, `pad_strong_pu` is 0 on both pins.
- R2: While `spi_mode` is 1, on pin i (0 = clock, 1 = data), `pad_strong_pu[i]` equals `spi_out[i] & spi_oe[i]` and `pad_pd_a[i]` equals `~spi_out[i] & spi_oe[i]`.
- R3: While `spi_mode` is 0, on each pin `pad_pd_a[i]` and `pad_pd_b[i]` both equal `~i2c_out[i]`; a 1 from the I2C engine drives nothing.
- R4: While `spi_mode` is 1, `pad_pd_b` is 0 on both pins.
- R5: `pad_weak_pu` is 1 on both pins in both modes.
- R6: On no pin are `pad_strong_pu` and either pull-down enable 1 at the same time.
- R7: During and right after reset, `i2c_clk_in`, `i2c_dat_in`, `spi_clk_in` and `spi_dat_in` read 1.
- R8: An I2C input (`i2c_clk_in` from `pad_clk`, `i2c_dat_in` from `pad_dat`) takes a new pad level GLITCH_CYCLES+2 rising edges after the pad changes, if the pad holds that level throughout.
- R9: A pad pulse on the I2C path that lasts GLITCH_CYCLES-1 clocks or less leaves the I2C input unchanged.
- R10: `spi_clk_in` follows `pad_clk` SPI_HOLD+2 edges after a held change, and ignores pulses shorter than SPI_HOLD clocks.
- R11: `spi_dat_in` follows `pad_dat` two rising edges after a change, with no filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_mode | input | 1 | 1 = SPI owns the pins, 0 = I2C owns them |
| spi_out | input | 2 | SPI engine output level per pin (bit 0 clock, bit 1 data) |
| spi_oe | input | 2 | SPI engine output enable per pin |
| i2c_out | input | 2 | I2C engine open-drain output per pin (0 pulls low) |
| pad_clk | input | 1 | Level sensed on the clock pin |
| pad_dat | input | 1 | Level sensed on the data pin |
| pad_strong_pu | output | 2 | Strong pull-up enable per pin |
| pad_weak_pu | output | 2 | Weak pull-up enable per pin |
| pad_pd_a | output | 2 | First pull-down enable per pin |
| pad_pd_b | output | 2 | Second pull-down enable per pin |
| i2c_clk_in | output | 1 | Glitch-filtered clock level to the I2C engine |
| i2c_dat_in | output | 1 | Glitch-filtered data level to the I2C engine |
| spi_clk_in | output | 1 | Debounced clock level to the SPI engine |
| spi_dat_in | output | 1 | Synchronized data level to the SPI engine |

## Verification
The drive outputs are combinational from the mode bit and the engine outputs. A fault in the drive mapping therefore shows on the pad enables at once, in the cycle the inputs are applied. The input paths hold state, so a corrupt synchronizer stage or filter counter shows only as a timing error. An edge arrives one or more clocks early or late, or a short pulse that should be rejected passes through. The bench finds these faults by checking the exact edge at which each input path flips, and by holding pulses one clock shorter than the filter length.

// File: rtl/serial_pad_pkg.sv
package serial_pad_pkg;
  localparam int unsigned PIN_COUNT = 2;
  localparam int unsigned PIN_CLK   = 0;
  localparam int unsigned PIN_DAT   = 1;

  typedef struct packed {
    logic strong_pu;
    logic weak_pu;
    logic pd_a;
    logic pd_b;
  } pad_drive_t;
endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

  // R11
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> (q == $past(chain[STAGES-2])));
endmodule

// File: rtl/pad_hold_filter.sv
module pad_hold_filter #(
  parameter int unsigned HOLD      = 8,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_cnt;
  logic          level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= RESET_VAL;
      run_cnt <= '0;
    end else if (d == level) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      level   <= d;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign q = level;

  // R9
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt < CW'(HOLD));

  // R8
  flip_matches_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> ($past(d) == q));

  // R9
  flip_needs_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> ($past(run_cnt) == LAST));
endmodule

// File: rtl/pad_drive_mux.sv
module pad_drive_mux
  import serial_pad_pkg::*;
(
  input  logic       spi_mode,
  input  logic       spi_out,
  input  logic       spi_oe,
  input  logic       i2c_out,
  output pad_drive_t drive
);
  always_comb begin
    drive.weak_pu = 1'b1;
    if (spi_mode) begin
      drive.strong_pu = spi_oe & spi_out;
      drive.pd_a      = spi_oe & ~spi_out;
      drive.pd_b      = 1'b0;
    end else begin
      drive.strong_pu = 1'b0;
      drive.pd_a      = ~i2c_out;
      drive.pd_b      = ~i2c_out;
    end
  end
endmodule

// File: rtl/serial_pad_ctrl.sv
module serial_pad_ctrl
  import serial_pad_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned GLITCH_CYCLES = 8,
  parameter int unsigned SPI_HOLD      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_mode,
  input  logic [1:0] spi_out,
  input  logic [1:0] spi_oe,
  input  logic [1:0] i2c_out,
  input  logic       pad_clk,
  input  logic       pad_dat,
  output logic [1:0] pad_strong_pu,
  output logic [1:0] pad_weak_pu,
  output logic [1:0] pad_pd_a,
  output logic [1:0] pad_pd_b,
  output logic       i2c_clk_in,
  output logic       i2c_dat_in,
  output logic       spi_clk_in,
  output logic       spi_dat_in
);
  pad_drive_t            drv [PIN_COUNT];
  logic [PIN_COUNT-1:0]  pad_raw;
  logic [PIN_COUNT-1:0]  pad_s;
  logic [PIN_COUNT-1:0]  i2c_filt;

  assign pad_raw[PIN_CLK] = pad_clk;
  assign pad_raw[PIN_DAT] = pad_dat;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    pad_drive_mux u_mux (
      .spi_mode (spi_mode),
      .spi_out  (spi_out[p]),
      .spi_oe   (spi_oe[p]),
      .i2c_out  (i2c_out[p]),
      .drive    (drv[p])
    );

    assign pad_strong_pu[p] = drv[p].strong_pu;
    assign pad_weak_pu[p]   = drv[p].weak_pu;
    assign pad_pd_a[p]      = drv[p].pd_a;
    assign pad_pd_b[p]      = drv[p].pd_b;

    pad_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_raw[p]),
      .q     (pad_s[p])
    );

    pad_hold_filter #(.HOLD(GLITCH_CYCLES), .RESET_VAL(1'b1)) u_i2c_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_s[p]),
      .q     (i2c_filt[p])
    );
  end

  pad_hold_filter #(.HOLD(SPI_HOLD), .RESET_VAL(1'b1)) u_spi_clk_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_s[PIN_CLK]),
    .q     (spi_clk_in)
  );

  assign i2c_clk_in = i2c_filt[PIN_CLK];
  assign i2c_dat_in = i2c_filt[PIN_DAT];
  assign spi_dat_in = pad_s[PIN_DAT];

  // R1
  i2c_no_strong_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_mode |-> (pad_strong_pu == 2'b00));

  // R3
  i2c_legs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_mode |-> ((pad_pd_a == pad_pd_b) && (pad_pd_a == ~i2c_out)));

  // R4
  spi_single_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |-> (pad_pd_b == 2'b00));

  // R2
  spi_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |-> (((pad_strong_pu | pad_pd_a) & ~spi_oe) == 2'b00));

  // R5
  weak_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_weak_pu == 2'b11);

  // R6
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_strong_pu & (pad_pd_a | pad_pd_b)) == 2'b00));
endmodule

// File: tb/serial_pad_ctrl_bench.sv
module serial_pad_ctrl_bench;
  localparam int unsigned GC = 8;
  localparam int unsigned SH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_mode = 1'b0;
  logic [1:0] spi_out = 2'b00;
  logic [1:0] spi_oe = 2'b00;
  logic [1:0] i2c_out = 2'b11;
  logic       pad_clk = 1'b1;
  logic       pad_dat = 1'b1;
  logic [1:0] pad_strong_pu, pad_weak_pu, pad_pd_a, pad_pd_b;
  logic       i2c_clk_in, i2c_dat_in, spi_clk_in, spi_dat_in;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_pad_ctrl #(.SYNC_STAGES(2), .GLITCH_CYCLES(GC), .SPI_HOLD(SH)) u_serial_pad_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .spi_out(spi_out),
    .spi_oe(spi_oe), .i2c_out(i2c_out), .pad_clk(pad_clk), .pad_dat(pad_dat),
    .pad_strong_pu(pad_strong_pu), .pad_weak_pu(pad_weak_pu),
    .pad_pd_a(pad_pd_a), .pad_pd_b(pad_pd_b),
    .i2c_clk_in(i2c_clk_in), .i2c_dat_in(i2c_dat_in),
    .spi_clk_in(spi_clk_in), .spi_dat_in(spi_dat_in)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_expect(input string req);
    logic [1:0] s, a, b;
    #1;
    for (int p = 0; p < 2; p++) begin
      if (spi_mode) begin
        s[p] = spi_oe[p] & spi_out[p];
        a[p] = spi_oe[p] & ~spi_out[p];
        b[p] = 1'b0;
      end else begin
        s[p] = 1'b0;
        a[p] = ~i2c_out[p];
        b[p] = ~i2c_out[p];
      end
    end
    check(req, "strong_pu", {6'd0, pad_strong_pu}, {6'd0, s});
    check(req, "pd_a", {6'd0, pad_pd_a}, {6'd0, a});
    check(req, "pd_b", {6'd0, pad_pd_b}, {6'd0, b});
    check("R5", "weak_pu", {6'd0, pad_weak_pu}, 8'h03);
    check("R6", "no_fight", {6'd0, pad_strong_pu & (pad_pd_a | pad_pd_b)}, 8'h00);
  endtask

  task automatic test_reset;
    edges(2);
    check("R7", "i2c_clk_in reset", {7'd0, i2c_clk_in}, 8'h01);
    check("R7", "i2c_dat_in reset", {7'd0, i2c_dat_in}, 8'h01);
    check("R7", "spi_clk_in reset", {7'd0, spi_clk_in}, 8'h01);
    check("R7", "spi_dat_in reset", {7'd0, spi_dat_in}, 8'h01);
    rst_n = 1'b1;
    edges(1);
    check("R7", "i2c_clk_in after reset", {7'd0, i2c_clk_in}, 8'h01);
    check("R7", "spi_clk_in after reset", {7'd0, spi_clk_in}, 8'h01);
  endtask

  task automatic test_i2c_drive;
    spi_mode = 1'b0;
    spi_oe = 2'b11;
    spi_out = 2'b11;
    for (int v = 0; v < 4; v++) begin
      i2c_out = 2'(v);
      drive_expect(v[0] ? "R1" : "R3");
      drive_expect("R3");
      edges(1);
    end
  endtask

  task automatic test_spi_drive;
    spi_mode = 1'b1;
    i2c_out = 2'b00;
    for (int v = 0; v < 16; v++) begin
      spi_out = 2'(v);
      spi_oe = 2'(v >> 2);
      drive_expect("R2");
      drive_expect("R4");
      edges(1);
    end
    spi_mode = 1'b0;
    i2c_out = 2'b11;
  endtask

  task automatic test_i2c_glitch_reject;
    pad_clk = 1'b0;
    edges(GC - 1);
    pad_clk = 1'b1;
    for (int k = 0; k < GC + 4; k++) begin
      edges(1);
      check("R9", "i2c_clk_in short pulse", {7'd0, i2c_clk_in}, 8'h01);
    end
    pad_dat = 1'b0;
    edges(1);
    pad_dat = 1'b1;
    for (int k = 0; k < 6; k++) begin
      edges(1);
      check("R9", "i2c_dat_in one-cycle pulse", {7'd0, i2c_dat_in}, 8'h01);
    end
  endtask

  task automatic test_i2c_pass;
    pad_dat = 1'b0;
    edges(GC + 1);
    check("R8", "i2c_dat_in one edge early", {7'd0, i2c_dat_in}, 8'h01);
    edges(1);
    check("R8", "i2c_dat_in falls", {7'd0, i2c_dat_in}, 8'h00);
    pad_dat = 1'b1;
    edges(GC + 1);
    check("R8", "i2c_dat_in still low", {7'd0, i2c_dat_in}, 8'h00);
    edges(1);
    check("R8", "i2c_dat_in rises", {7'd0, i2c_dat_in}, 8'h01);
  endtask

  task automatic test_spi_clk;
    pad_clk = 1'b0;
    edges(1);
    pad_clk = 1'b1;
    for (int k = 0; k < 5; k++) begin
      edges(1);
      check("R10", "spi_clk_in short pulse", {7'd0, spi_clk_in}, 8'h01);
    end
    pad_clk = 1'b0;
    edges(SH + 1);
    check("R10", "spi_clk_in early", {7'd0, spi_clk_in}, 8'h01);
    edges(1);
    check("R10", "spi_clk_in falls", {7'd0, spi_clk_in}, 8'h00);
    check("R9", "i2c_clk_in not yet", {7'd0, i2c_clk_in}, 8'h01);
    pad_clk = 1'b1;
    edges(SH + 2);
    check("R10", "spi_clk_in rises", {7'd0, spi_clk_in}, 8'h01);
    edges(GC);
    check("R9", "i2c_clk_in untouched", {7'd0, i2c_clk_in}, 8'h01);
  endtask

  task automatic test_spi_dat;
    pad_dat = 1'b0;
    edges(1);
    check("R11", "spi_dat_in early", {7'd0, spi_dat_in}, 8'h01);
    edges(1);
    check("R11", "spi_dat_in falls", {7'd0, spi_dat_in}, 8'h00);
    pad_dat = 1'b1;
    edges(2);
    check("R11", "spi_dat_in rises after one-level pulse", {7'd0, spi_dat_in}, 8'h01);
    edges(GC + 2);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    test_reset();
    test_i2c_drive();
    test_spi_drive();
    test_i2c_glitch_reject();
    test_i2c_pass();
    test_spi_clk();
    test_spi_dat();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule